// File: doc/BRIEF.md
# Cartridge Bank-Extension Address Decoder

This block is the glue between a host CPU bus, a graphics bus and an existing bank-switching controller on a cartridge board. For every CPU access it chooses between the work-RAM window, the program ROM and the controller's register port. For every graphics access it chooses between nametable RAM and pattern memory. It forms the memory addresses, selects the read data and gates the write strobes. The controller's serial register logic is not part of this block. Its outputs arrive as input ports: the mapped program address, the mapped pattern and nametable addresses, the RAM-disable flag and the upper bits [4:2] of its first pattern-bank register.

The board variant is fixed by the `VARIANT` parameter, and it decides what the spare pattern-bank bits do. They can extend the work-RAM bank, gate the work RAM off, or add a high program-ROM address bit.

A one-byte open-bus register holds the last byte seen on the CPU data bus. Reads that reach no device return this byte.

Top module: `cart_bank_ext_decoder`

## Requirements
- R1: A CPU address with bits [15:13] = 3'b011 hits the work-RAM window. The work-RAM address is {bank, cpu_addr[12:0]}, which is 15 bits wide with a 2-bit bank.
- R2: The work-RAM bank depends on the variant. VARIANT 0 (plain) and 3 (gated) use bank 0. VARIANT 1 uses {1'b0, chr_hi[1]}. VARIANT 2 and VARIANT 4 (wide) use chr_hi[1:0]. Here chr_hi[k] is pattern-bank register 0 bit k+2.
- R3: In VARIANT 3, chr_hi[2]=1 means a work-RAM write produces no write strobe, and a work-RAM read returns the open-bus byte. This gate takes precedence over R4.
- R4: When ram_disable=1, work-RAM reads return 8'h00 and work-RAM writes produce no strobe.
- R5: A CPU read with cpu_addr[15]=1 returns prg_rom_rdata. The program-ROM address is {hi, ctl_prg_addr}. Here hi is chr_hi[2] in VARIANT 4 and 0 in every other variant.
- R6: A CPU write with cpu_addr[15]=1 raises ctl_reg_wr and never raises the work-RAM write strobe.
- R7: A CPU read below 16'h6000 returns the open-bus byte. A write below 16'h6000 raises no strobe.
- R8: The open-bus byte resets to 8'h00. After each CPU write it takes cpu_wdata, and after each CPU read it takes the returned byte.
- R9: A graphics access with gfx_addr[13]=1 goes to nametable RAM at ctl_nt_addr. On a write, only ntram_we rises, and reads return ntram_rdata.
- R10: A graphics access with gfx_addr[13]=0 goes to pattern memory at ctl_pat_addr. On a write, only pat_we rises, and reads return pat_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read cycle |
| cpu_wr | input | 1 | CPU write cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| ctl_prg_addr | input | 18 | Controller-mapped program-ROM address |
| ctl_chr_hi | input | 3 | Pattern-bank register 0 bits [4:2] |
| ctl_ram_disable | input | 1 | Controller work-RAM disable flag |
| ctl_reg_wr | output | 1 | Write strobe to the controller register port |
| prg_rom_addr | output | 19 | Program-ROM address |
| prg_rom_rdata | input | 8 | Program-ROM read data |
| wram_addr | output | 15 | Work-RAM address |
| wram_we | output | 1 | Work-RAM write strobe |
| wram_rdata | input | 8 | Work-RAM read data |
| gfx_addr | input | 14 | Graphics address |
| gfx_wr | input | 1 | Graphics write cycle |
| gfx_rdata | output | 8 | Graphics read data |
| ctl_nt_addr | input | 11 | Controller nametable (mirroring) address |
| ctl_pat_addr | input | 17 | Controller-mapped pattern address |
| ntram_addr | output | 11 | Nametable RAM address |
| ntram_we | output | 1 | Nametable RAM write strobe |
| ntram_rdata | input | 8 | Nametable RAM read data |
| pat_addr | output | 17 | Pattern memory address |
| pat_we | output | 1 | Pattern memory write strobe |
| pat_rdata | input | 8 | Pattern memory read data |

## Verification
The hardest case to reach is the gated variant with its gate closed and ram_disable also set. Here the open-bus byte must win over the forced zero, and that byte itself depends on the access before it. The bench builds all five variants side by side on shared stimulus. It sweeps every value of the three spare bits against both RAM-disable settings and six addresses spread over every window. Each address gets a write followed by a read, so the byte held by the open-bus register is always a known, freshly written value when the gated read arrives.

// File: rtl/cart_ext_pkg.sv
package cart_ext_pkg;
  typedef enum logic [2:0] {
    VAR_PLAIN    = 3'd0,
    VAR_RAM_B1   = 3'd1,
    VAR_RAM_B2   = 3'd2,
    VAR_RAM_GATE = 3'd3,
    VAR_WIDE     = 3'd4
  } board_var_e;

  localparam int DW_DEF         = 8;
  localparam int CTL_PRG_AW_DEF = 18;
  localparam int WRAM_BANK_W_DEF = 2;
  localparam int WRAM_OFS_W     = 13;
  localparam int NT_AW_DEF      = 11;
  localparam int PAT_AW_DEF     = 17;
endpackage

// File: rtl/cart_rst_sync.sv
module cart_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cart_wram_bank_sel.sv
module cart_wram_bank_sel
  import cart_ext_pkg::*;
#(
  parameter board_var_e VARIANT     = VAR_WIDE,
  parameter int         WRAM_BANK_W = WRAM_BANK_W_DEF
) (
  input  logic [2:0]             chr_hi,
  output logic [WRAM_BANK_W-1:0] bank,
  output logic                   gate_closed,
  output logic                   prg_hi
);
  logic unused_chr;
  assign unused_chr = ^chr_hi;

  generate
    if (VARIANT == VAR_RAM_B1) begin : g_b1
      assign bank        = WRAM_BANK_W'(chr_hi[1]);
      assign gate_closed = 1'b0;
      assign prg_hi      = 1'b0;
    end else if (VARIANT == VAR_RAM_B2) begin : g_b2
      assign bank        = WRAM_BANK_W'(chr_hi[1:0]);
      assign gate_closed = 1'b0;
      assign prg_hi      = 1'b0;
    end else if (VARIANT == VAR_RAM_GATE) begin : g_gate
      assign bank        = '0;
      assign gate_closed = chr_hi[2];
      assign prg_hi      = 1'b0;
    end else if (VARIANT == VAR_WIDE) begin : g_wide
      assign bank        = WRAM_BANK_W'(chr_hi[1:0]);
      assign gate_closed = 1'b0;
      assign prg_hi      = chr_hi[2];
    end else begin : g_plain
      assign bank        = '0;
      assign gate_closed = 1'b0;
      assign prg_hi      = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/cart_cpu_router.sv
module cart_cpu_router
  import cart_ext_pkg::*;
#(
  parameter int DW          = DW_DEF,
  parameter int CTL_PRG_AW  = CTL_PRG_AW_DEF,
  parameter int WRAM_BANK_W = WRAM_BANK_W_DEF,
  localparam int PRG_AW     = CTL_PRG_AW + 1,
  localparam int WRAM_AW    = WRAM_BANK_W + WRAM_OFS_W
) (
  input  logic [15:0]            cpu_addr,
  input  logic                   cpu_wr,
  input  logic [CTL_PRG_AW-1:0]  ctl_prg_addr,
  input  logic                   ram_disable,
  input  logic                   gate_closed,
  input  logic                   prg_hi,
  input  logic [WRAM_BANK_W-1:0] bank,
  input  logic [DW-1:0]          prg_rdata,
  input  logic [DW-1:0]          wram_rdata,
  input  logic [DW-1:0]          open_bus,
  output logic [DW-1:0]          rdata,
  output logic [PRG_AW-1:0]      prg_addr,
  output logic [WRAM_AW-1:0]     wram_addr,
  output logic                   wram_we,
  output logic                   reg_wr
);
  logic hit_rom, hit_wram;

  assign hit_rom   = cpu_addr[15];
  assign hit_wram  = (cpu_addr[15:13] == 3'b011);
  assign prg_addr  = {prg_hi, ctl_prg_addr};
  assign wram_addr = {bank, cpu_addr[WRAM_OFS_W-1:0]};
  assign wram_we   = cpu_wr & hit_wram & ~gate_closed & ~ram_disable;
  assign reg_wr    = cpu_wr & hit_rom;

  always_comb begin
    rdata = open_bus;
    if (hit_rom) begin
      rdata = prg_rdata;
    end else if (hit_wram) begin
      if (gate_closed)      rdata = open_bus;
      else if (ram_disable) rdata = '0;
      else                  rdata = wram_rdata;
    end
  end
endmodule

// File: rtl/cart_open_bus.sv
module cart_open_bus
  import cart_ext_pkg::*;
#(
  parameter int DW = DW_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic [DW-1:0] cpu_rdata,
  output logic [DW-1:0] bus_q
);
  logic          bus_en;
  logic [DW-1:0] bus_d;

  always_comb begin
    bus_en = cpu_rd | cpu_wr;
    bus_d  = cpu_wr ? cpu_wdata : cpu_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_q <= '0;
    else if (bus_en) bus_q <= bus_d;
  end
endmodule

// File: rtl/cart_gfx_router.sv
module cart_gfx_router
  import cart_ext_pkg::*;
#(
  parameter int DW     = DW_DEF,
  parameter int NT_AW  = NT_AW_DEF,
  parameter int PAT_AW = PAT_AW_DEF
) (
  input  logic              sel_nt,
  input  logic              gfx_wr,
  input  logic [NT_AW-1:0]  ctl_nt_addr,
  input  logic [PAT_AW-1:0] ctl_pat_addr,
  input  logic [DW-1:0]     ntram_rdata,
  input  logic [DW-1:0]     pat_rdata,
  output logic [DW-1:0]     gfx_rdata,
  output logic [NT_AW-1:0]  ntram_addr,
  output logic              ntram_we,
  output logic [PAT_AW-1:0] pat_addr,
  output logic              pat_we
);
  assign ntram_addr = ctl_nt_addr;
  assign pat_addr   = ctl_pat_addr;
  assign ntram_we   = gfx_wr & sel_nt;
  assign pat_we     = gfx_wr & ~sel_nt;
  assign gfx_rdata  = sel_nt ? ntram_rdata : pat_rdata;
endmodule

// File: rtl/cart_bank_ext_decoder.sv
module cart_bank_ext_decoder
  import cart_ext_pkg::*;
#(
  parameter board_var_e VARIANT     = VAR_WIDE,
  parameter int         DW          = DW_DEF,
  parameter int         CTL_PRG_AW  = CTL_PRG_AW_DEF,
  parameter int         WRAM_BANK_W = WRAM_BANK_W_DEF,
  parameter int         NT_AW       = NT_AW_DEF,
  parameter int         PAT_AW      = PAT_AW_DEF,
  localparam int        PRG_AW      = CTL_PRG_AW + 1,
  localparam int        WRAM_AW     = WRAM_BANK_W + WRAM_OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [15:0]           cpu_addr,
  input  logic                  cpu_rd,
  input  logic                  cpu_wr,
  input  logic [DW-1:0]         cpu_wdata,
  output logic [DW-1:0]         cpu_rdata,
  input  logic [CTL_PRG_AW-1:0] ctl_prg_addr,
  input  logic [2:0]            ctl_chr_hi,
  input  logic                  ctl_ram_disable,
  output logic                  ctl_reg_wr,
  output logic [PRG_AW-1:0]     prg_rom_addr,
  input  logic [DW-1:0]         prg_rom_rdata,
  output logic [WRAM_AW-1:0]    wram_addr,
  output logic                  wram_we,
  input  logic [DW-1:0]         wram_rdata,
  input  logic [13:0]           gfx_addr,
  input  logic                  gfx_wr,
  output logic [DW-1:0]         gfx_rdata,
  input  logic [NT_AW-1:0]      ctl_nt_addr,
  input  logic [PAT_AW-1:0]     ctl_pat_addr,
  output logic [NT_AW-1:0]      ntram_addr,
  output logic                  ntram_we,
  input  logic [DW-1:0]         ntram_rdata,
  output logic [PAT_AW-1:0]     pat_addr,
  output logic                  pat_we,
  input  logic [DW-1:0]         pat_rdata
);
  logic                   rst_sync_n;
  logic [WRAM_BANK_W-1:0] bank;
  logic                   gate_closed, prg_hi;
  logic [DW-1:0]          open_bus;
  logic                   unused_gfx;

  assign unused_gfx = ^gfx_addr[12:0];

  cart_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  cart_wram_bank_sel #(.VARIANT(VARIANT), .WRAM_BANK_W(WRAM_BANK_W)) u_bank (
    .chr_hi(ctl_chr_hi), .bank(bank), .gate_closed(gate_closed), .prg_hi(prg_hi)
  );

  cart_cpu_router #(.DW(DW), .CTL_PRG_AW(CTL_PRG_AW), .WRAM_BANK_W(WRAM_BANK_W)) u_cpu (
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .ctl_prg_addr(ctl_prg_addr),
    .ram_disable(ctl_ram_disable), .gate_closed(gate_closed), .prg_hi(prg_hi),
    .bank(bank), .prg_rdata(prg_rom_rdata), .wram_rdata(wram_rdata),
    .open_bus(open_bus), .rdata(cpu_rdata), .prg_addr(prg_rom_addr),
    .wram_addr(wram_addr), .wram_we(wram_we), .reg_wr(ctl_reg_wr)
  );

  cart_open_bus #(.DW(DW)) u_ob (
    .clk(clk), .rst_n(rst_sync_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_q(open_bus)
  );

  cart_gfx_router #(.DW(DW), .NT_AW(NT_AW), .PAT_AW(PAT_AW)) u_gfx (
    .sel_nt(gfx_addr[13]), .gfx_wr(gfx_wr), .ctl_nt_addr(ctl_nt_addr),
    .ctl_pat_addr(ctl_pat_addr), .ntram_rdata(ntram_rdata), .pat_rdata(pat_rdata),
    .gfx_rdata(gfx_rdata), .ntram_addr(ntram_addr), .ntram_we(ntram_we),
    .pat_addr(pat_addr), .pat_we(pat_we)
  );
endmodule

// File: rtl/cart_ext_chk.sv
module cart_ext_chk
  import cart_ext_pkg::*;
#(
  parameter board_var_e VARIANT = VAR_WIDE,
  parameter int         DW      = DW_DEF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [15:0]   cpu_addr,
  input logic          cpu_rd,
  input logic          cpu_wr,
  input logic [DW-1:0] cpu_wdata,
  input logic [DW-1:0] cpu_rdata,
  input logic [2:0]    chr_hi,
  input logic          ram_disable,
  input logic          wram_we,
  input logic          reg_wr,
  input logic          prg_hi,
  input logic          gfx_nt,
  input logic          gfx_wr,
  input logic          ntram_we,
  input logic          pat_we
);
  logic past_ok;
  logic in_wram;

  assign in_wram = (cpu_addr[15:13] == 3'b011);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R4
  ram_off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && in_wram && ram_disable) |-> !wram_we);

  // R3
  gate_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT == VAR_RAM_GATE && cpu_wr && chr_hi[2]) |-> !wram_we);

  // R6
  reg_port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |-> (reg_wr && !wram_we));

  // R5
  prg_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT != VAR_WIDE) |-> !prg_hi);

  // R8
  open_bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cpu_wr) && cpu_rd && !cpu_wr && cpu_addr[15:13] < 3'b011)
      |-> (cpu_rdata == $past(cpu_wdata)));

  // R9
  nt_write_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_wr && gfx_nt) |-> (ntram_we && !pat_we));

  // R10
  pat_write_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gfx_wr && !gfx_nt) |-> (pat_we && !ntram_we));
endmodule

bind cart_bank_ext_decoder cart_ext_chk #(.VARIANT(VARIANT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
  .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .chr_hi(ctl_chr_hi), .ram_disable(ctl_ram_disable), .wram_we(wram_we),
  .reg_wr(ctl_reg_wr), .prg_hi(prg_rom_addr[PRG_AW-1]), .gfx_nt(gfx_addr[13]),
  .gfx_wr(gfx_wr), .ntram_we(ntram_we), .pat_we(pat_we)
);

// File: tb/cart_bank_ext_decoder_tb.sv
`timescale 1ns/1ps
module cart_bank_ext_decoder_tb;
  import cart_ext_pkg::*;
  localparam int NV = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [17:0] ctl_prg_addr = '0;
  logic [2:0]  ctl_chr_hi = '0;
  logic        ctl_ram_disable = 1'b0;
  logic [7:0]  prg_rom_rdata = '0, wram_rdata = '0, ntram_rdata = '0, pat_rdata = '0;
  logic [13:0] gfx_addr = '0;
  logic        gfx_wr = 1'b0;
  logic [10:0] ctl_nt_addr = '0;
  logic [16:0] ctl_pat_addr = '0;

  logic [7:0]  cpu_rdata_a [NV];
  logic        reg_wr_a [NV];
  logic [18:0] prg_addr_a [NV];
  logic [14:0] wram_addr_a [NV];
  logic        wram_we_a [NV];
  logic [7:0]  gfx_rdata_a [NV];
  logic [10:0] nt_addr_a [NV];
  logic        nt_we_a [NV];
  logic [16:0] pat_addr_a [NV];
  logic        pat_we_a [NV];

  int compared = 0, mismatched = 0;
  logic [7:0] ob [NV];

  always #5 clk = ~clk;

  for (genvar v = 0; v < NV; v++) begin : g_var
    cart_bank_ext_decoder #(.VARIANT(board_var_e'(v))) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
      .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata_a[v]),
      .ctl_prg_addr(ctl_prg_addr), .ctl_chr_hi(ctl_chr_hi),
      .ctl_ram_disable(ctl_ram_disable), .ctl_reg_wr(reg_wr_a[v]),
      .prg_rom_addr(prg_addr_a[v]), .prg_rom_rdata(prg_rom_rdata),
      .wram_addr(wram_addr_a[v]), .wram_we(wram_we_a[v]), .wram_rdata(wram_rdata),
      .gfx_addr(gfx_addr), .gfx_wr(gfx_wr), .gfx_rdata(gfx_rdata_a[v]),
      .ctl_nt_addr(ctl_nt_addr), .ctl_pat_addr(ctl_pat_addr),
      .ntram_addr(nt_addr_a[v]), .ntram_we(nt_we_a[v]), .ntram_rdata(ntram_rdata),
      .pat_addr(pat_addr_a[v]), .pat_we(pat_we_a[v]), .pat_rdata(pat_rdata)
    );
  end

  task automatic chk(input string req, input int v, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s variant=%0d actual=%h expected=%h", req, v, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_bank(input int v, input logic [2:0] c);
    if (v == 1)           return {1'b0, c[1]};
    if (v == 2 || v == 4) return c[1:0];
    return 2'b00;
  endfunction

  task automatic do_op(input logic [15:0] a, input logic wr, input logic [2:0] c,
                       input logic dis, input logic [7:0] wd, input int ai);
    @(negedge clk);
    cpu_addr = a; cpu_rd = ~wr; cpu_wr = wr; cpu_wdata = wd;
    ctl_chr_hi = c; ctl_ram_disable = dis;
    ctl_prg_addr = {2'(c), 3'(ai), a[12:0]};
    prg_rom_rdata = 8'h80 ^ {5'd0, c} ^ 8'(ai << 4);
    wram_rdata = 8'h40 ^ {5'd0, c} ^ 8'(ai);
    ntram_rdata = 8'h11 ^ {5'd0, c};
    pat_rdata = 8'h22 ^ {5'd0, c};
    gfx_addr = {ai[0] ^ dis, 13'(c * 263 + ai * 1031)};
    gfx_wr = wr;
    ctl_nt_addr = 11'(c * 7 + ai);
    ctl_pat_addr = 17'(c * 513 + ai);
    #1;
    for (int v = 0; v < NV; v++) begin
      logic rom, win, gate;
      logic [7:0] er;
      rom  = a[15];
      win  = (a[15:13] == 3'b011);
      gate = (v == 3) && c[2];
      if (rom)       er = prg_rom_rdata;
      else if (win)  er = gate ? ob[v] : (dis ? 8'h00 : wram_rdata);
      else           er = ob[v];
      if (!wr) begin
        if (rom)       chk("R5 rom read data", v, 32'(cpu_rdata_a[v]), 32'(er));
        else if (!win) chk("R7 open-bus read", v, 32'(cpu_rdata_a[v]), 32'(er));
        else if (gate) chk("R3 gated read", v, 32'(cpu_rdata_a[v]), 32'(er));
        else if (dis)  chk("R4 disabled read", v, 32'(cpu_rdata_a[v]), 32'(er));
        else           chk("R1 wram read data", v, 32'(cpu_rdata_a[v]), 32'(er));
      end
      if (win) chk("R1 R2 wram address", v, 32'(wram_addr_a[v]), 32'({exp_bank(v, c), a[12:0]}));
      if (rom) chk("R5 rom address", v, 32'(prg_addr_a[v]),
                   32'({(v == 4) ? c[2] : 1'b0, ctl_prg_addr}));
      if (win && gate)      chk("R3 gated write strobe", v, 32'(wram_we_a[v]), 32'(0));
      else if (win && dis)  chk("R4 disabled write strobe", v, 32'(wram_we_a[v]), 32'(0));
      else if (win)         chk("R1 wram write strobe", v, 32'(wram_we_a[v]), 32'(wr));
      else                  chk("R7 R6 no wram strobe", v, 32'(wram_we_a[v]), 32'(0));
      chk("R6 register write", v, 32'(reg_wr_a[v]), 32'(wr & rom));
      if (gfx_addr[13]) begin
        chk("R9 nametable route", v, 32'({nt_addr_a[v], nt_we_a[v], pat_we_a[v], gfx_rdata_a[v]}),
            32'({ctl_nt_addr, wr, 1'b0, ntram_rdata}));
      end else begin
        chk("R10 pattern route", v, 32'({pat_addr_a[v], pat_we_a[v], nt_we_a[v]}),
            32'({ctl_pat_addr, wr, 1'b0}));
        chk("R10 pattern data", v, 32'(gfx_rdata_a[v]), 32'(pat_rdata));
      end
      ob[v] = wr ? wd : er;
    end
    @(posedge clk);
  endtask

  initial begin : watchdog
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [15:0] bases [6];
    bases = '{16'h4123, 16'h5FFF, 16'h6000, 16'h7ABC, 16'h8000, 16'hFFFF};
    for (int v = 0; v < NV; v++) ob[v] = 8'h00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R8: reset value of the open-bus byte seen through a low read
    do_op(16'h4000, 1'b0, 3'd0, 1'b0, 8'h00, 0);
    for (int c = 0; c < 8; c++) begin
      for (int d = 0; d < 2; d++) begin
        for (int ai = 0; ai < 6; ai++) begin
          logic [15:0] a;
          logic [7:0] wd;
          a  = bases[ai] ^ 16'(c << 5);
          wd = 8'(c * 37 + ai * 11 + d * 101 + 3);
          do_op(a, 1'b1, 3'(c), d[0], wd, ai);
          // R8: read right after a write sees the written byte where no device answers
          do_op(a, 1'b0, 3'(c), d[0], 8'h00, ai);
        end
      end
    end
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0; gfx_wr = 1'b0;
    repeat (2) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule